// File: doc/BRIEF.md
# Bit-Group Rotate/Shift/Bit Unit

This execution unit serves the bit-manipulation opcode group of an 8-bit processor core. Each cycle in which `valid_i` is high, it takes the second opcode byte, the 8-bit operand that the fetch logic has already read, and the incoming carry flag. It decodes the opcode into a group, a kind or bit number, and an operand selector.

It then produces a registered result with carry, zero, sign and parity flags, plus a write-back enable. Results appear one cycle after the request. Operand fetch, register storage and indexed memory sequencing are handled elsewhere. The unit only reports, through `reg_sel_o`, which operand slot the result belongs to.

Beside the usual seven rotate and shift kinds, the unit fills the otherwise empty kind slot 6 with a left shift that always sets bit 0 to one.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits 7:6 choose the group: 00 rotate/shift, 01 bit test, 10 clear bit, 11 set bit.
- R2: In the rotate/shift group, opcode bits 5:3 choose the kind:
  - 0: circular left; carry takes bit 7.
  - 1: circular right; carry takes bit 0.
  - 2: left through carry.
  - 3: right through carry.
  - 4: left shift inserting 0; carry takes bit 7.
  - 5: arithmetic right shift keeping bit 7; carry takes bit 0.
  - 6: left shift inserting 1.
  - 7: logical right shift inserting 0; carry takes bit 0.
- R3: Kind 6 moves bits 0..6 up to bits 1..7, puts the old bit 7 in carry, and sets result bit 0 to 1 whatever the operand and carry-in are.
- R4: `reg_sel_o` presents opcode bits 2:0 of the accepted request. The codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A.
- R5: A bit test (group 01) on bit n = opcode bits 5:3 behaves as follows:
  - zero and parity are 1 when operand bit n is 0;
  - sign is 1 only when n is 7 and the bit is 1;
  - carry follows `carry_i`;
  - the result equals the operand;
  - `wb_o` stays 0.
- R6: Clear-bit and set-bit (groups 10 and 11) return the operand with bit n (opcode bits 5:3) forced to 0 or 1. They assert `wb_o` and leave carry, zero, sign and parity at their previous values.
- R7: After a rotate/shift, zero is 1 when the result is 0. Sign is result bit 7. Parity is 1 when the result has an even number of ones. `wb_o` is 1.
- R8: Outputs update on the clock edge after the edge that samples `valid_i` high, and `valid_o` follows `valid_i` with that one-cycle delay. In a cycle without a request, `valid_o` and `wb_o` are 0 and the result and flags hold.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 8 | Second opcode byte |
| data_i | input | 8 | Operand value |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Result value |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| parity_o | output | 1 | Even-parity flag |
| wb_o | output | 1 | Write the result back to the selected operand |
| reg_sel_o | output | 3 | Operand selector of the result |
| valid_o | output | 1 | Outputs carry a new result |

## Verification
The bench builds the unit with its default 8-bit width. This is the only width at which the 3-bit opcode fields cover every bit position, so all eight kinds and all eight bit numbers can be reached.

A sweep of every opcode over several edge operands (0x00, 0xFF, 0x80, 0x01) with both carry values reaches the following cases:
- the forced bit 0 of kind 6 when the operand is zero;
- sign raised only by a bit-7 test;
- flags held across clear and set.

Random runs with idle gaps show that the result and flags hold between requests.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned OP_W  = 8;
  localparam int unsigned FLD_W = 3;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    K_ROL_C  = 3'd0,
    K_ROR_C  = 3'd1,
    K_ROL_T  = 3'd2,
    K_ROR_T  = 3'd3,
    K_SHL_0  = 3'd4,
    K_SHR_A  = 3'd5,
    K_SHL_1  = 3'd6,
    K_SHR_0  = 3'd7
  } kind_e;

  typedef struct packed {
    grp_e             grp;
    logic [FLD_W-1:0] field;
    logic [FLD_W-1:0] sel;
  } op_fields_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  output grp_e             grp_o,
  output kind_e            kind_o,
  output logic [FLD_W-1:0] field_o,
  output logic [FLD_W-1:0] sel_o
);
  op_fields_t f;

  assign f       = op_fields_t'(op_i);
  assign grp_o   = f.grp;
  assign kind_o  = kind_e'(f.field);
  assign field_o = f.field;
  assign sel_o   = f.sel;
endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  kind_e          kind_i,
  input  logic [W-1:0]   data_i,
  input  logic           carry_i,
  output logic [W-1:0]   res_o,
  output logic           carry_o
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    res_o   = data_i;
    carry_o = data_i[MSB];
    unique case (kind_i)
      K_ROL_C: begin res_o = {data_i[MSB-1:0], data_i[MSB]}; carry_o = data_i[MSB]; end
      K_ROR_C: begin res_o = {data_i[0], data_i[MSB:1]};     carry_o = data_i[0];   end
      K_ROL_T: begin res_o = {data_i[MSB-1:0], carry_i};     carry_o = data_i[MSB]; end
      K_ROR_T: begin res_o = {carry_i, data_i[MSB:1]};       carry_o = data_i[0];   end
      K_SHL_0: begin res_o = {data_i[MSB-1:0], 1'b0};        carry_o = data_i[MSB]; end
      K_SHR_A: begin res_o = {data_i[MSB], data_i[MSB:1]};   carry_o = data_i[0];   end
      K_SHL_1: begin res_o = {data_i[MSB-1:0], 1'b1};        carry_o = data_i[MSB]; end
      K_SHR_0: begin res_o = {1'b0, data_i[MSB:1]};          carry_o = data_i[0];   end
      default: begin res_o = data_i;                         carry_o = carry_i;     end
    endcase
  end
endmodule

// File: rtl/bitop_bitmod.sv
module bitop_bitmod #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     res_o,
  output logic             bit_o
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  assign res_o = set_i ? (data_i | mask) : (data_i & ~mask);
  assign bit_o = |(data_i & mask);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     data_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             parity_o,
  output logic             wb_o,
  output logic [FLD_W-1:0] reg_sel_o,
  output logic             valid_o
);
  localparam int unsigned IDX_W = FLD_W;

  grp_e             grp;
  kind_e            kind;
  logic [FLD_W-1:0] field, sel;
  logic [W-1:0]     sh_res, bm_res;
  logic             sh_c, bm_bit;

  logic [W-1:0]     res_n;
  logic             c_n, z_n, s_n, p_n, wb_n;

  bitop_decode u_dec (
    .op_i    (op_i),
    .grp_o   (grp),
    .kind_o  (kind),
    .field_o (field),
    .sel_o   (sel)
  );

  bitop_shift #(.W(W)) u_sh (
    .kind_i  (kind),
    .data_i  (data_i),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .carry_o (sh_c)
  );

  bitop_bitmod #(.W(W), .IDX_W(IDX_W)) u_bm (
    .idx_i  (field),
    .set_i  (grp == GRP_SET),
    .data_i (data_i),
    .res_o  (bm_res),
    .bit_o  (bm_bit)
  );

  always_comb begin
    res_n = result_o;
    c_n   = carry_o;
    z_n   = zero_o;
    s_n   = sign_o;
    p_n   = parity_o;
    wb_n  = 1'b0;
    unique case (grp)
      GRP_SHIFT: begin
        res_n = sh_res;
        c_n   = sh_c;
        z_n   = ~|sh_res;
        s_n   = sh_res[W-1];
        p_n   = ~^sh_res;
        wb_n  = 1'b1;
      end
      GRP_TEST: begin
        res_n = data_i;
        c_n   = carry_i;
        z_n   = ~bm_bit;
        s_n   = bm_bit & (field == IDX_W'(W - 1));
        p_n   = ~bm_bit;
      end
      default: begin
        res_n = bm_res;
        wb_n  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      carry_o   <= 1'b0;
      zero_o    <= 1'b0;
      sign_o    <= 1'b0;
      parity_o  <= 1'b0;
      wb_o      <= 1'b0;
      reg_sel_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wb_o    <= valid_i & wb_n;
      if (valid_i) begin
        result_o  <= res_n;
        carry_o   <= c_n;
        zero_o    <= z_n;
        sign_o    <= s_n;
        parity_o  <= p_n;
        reg_sel_o <= sel;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] op_i,
  input logic [7:0] result_o,
  input logic       carry_o,
  input logic       zero_o,
  input logic       sign_o,
  input logic       parity_o,
  input logic       wb_o,
  input logic [2:0] reg_sel_o,
  input logic       valid_o
);
  p_valid_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(result_o) && !wb_o && !valid_o));

  p_test_no_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[7:6] == 2'b01) |-> !wb_o);

  p_slot6_bit0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[7:3] == 5'b00110) |-> result_o[0]);

  p_setclr_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[7]) |-> ($stable({carry_o, zero_o, sign_o, parity_o}) && wb_o));

  p_set_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[7:6] == 2'b11) |-> result_o[$past(op_i[5:3])]);

  p_shift_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i[7:6] == 2'b00) |-> (zero_o == (result_o == 8'h00)));

  p_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> (reg_sel_o == $past(op_i[2:0])));
endmodule

bind bitop_unit bitop_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o),
  .sign_o    (sign_o),
  .parity_o  (parity_o),
  .wb_o      (wb_o),
  .reg_sel_o (reg_sel_o),
  .valid_o   (valid_o)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] op_i = '0;
  logic [7:0] data_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] result_o;
  logic       carry_o, zero_o, sign_o, parity_o, wb_o, valid_o;
  logic [2:0] reg_sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int e_res = 0, e_c = 0, e_z = 0, e_s = 0, e_p = 0, e_wb = 0, e_sel = 0, e_v = 0;

  always #5 clk_i = ~clk_i;

  bitop_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .data_i(data_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o),
    .zero_o(zero_o), .sign_o(sign_o), .parity_o(parity_o), .wb_o(wb_o),
    .reg_sel_o(reg_sel_o), .valid_o(valid_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic model(input bit v, input int op, input int d, input int ci);
    int g, f, b, r, co;
    e_v = v;
    e_wb = 0;
    if (!v) return;
    g = (op >> 6) & 3;
    f = (op >> 3) & 7;
    e_sel = op & 7;
    b = (d >> f) & 1;
    if (g == 0) begin
      case (f)
        0: begin r = (d * 2 + d / 128) % 256;    co = d / 128; end
        1: begin r = d / 2 + (d % 2) * 128;      co = d % 2;   end
        2: begin r = (d * 2 + ci) % 256;         co = d / 128; end
        3: begin r = d / 2 + ci * 128;           co = d % 2;   end
        4: begin r = (d * 2) % 256;              co = d / 128; end
        5: begin r = d / 2 + (d / 128) * 128;    co = d % 2;   end
        6: begin r = (d * 2 + 1) % 256;          co = d / 128; end
        default: begin r = d / 2;                co = d % 2;   end
      endcase
      e_res = r; e_c = co; e_z = (r == 0); e_s = r / 128;
      e_p = (ones(r) % 2 == 0); e_wb = 1;
    end else if (g == 1) begin
      e_res = d; e_c = ci; e_z = !b; e_p = !b; e_s = (f == 7) && b;
    end else begin
      if (g == 3) e_res = d | (1 << f);
      else        e_res = d & ~(1 << f) & 255;
      e_wb = 1;
    end
  endtask

  task automatic step(input bit v, input int op, input int d, input int ci);
    string tg;
    int g;
    @(negedge clk_i);
    valid_i = v; op_i = op[7:0]; data_i = d[7:0]; carry_i = ci[0];
    model(v, op, d, ci);
    g = (op >> 6) & 3;
    if (!v) tg = "R8";
    else if (g == 0 && ((op >> 3) & 7) == 6) tg = "R3";
    else if (g == 0) tg = "R1/R2/R7";
    else if (g == 1) tg = "R1/R5";
    else tg = "R1/R6";
    @(negedge clk_i);
    chk(tg, "result", int'(result_o), e_res);
    chk(tg, "carry", int'(carry_o), e_c);
    chk(tg, "zero", int'(zero_o), e_z);
    chk(tg, "sign", int'(sign_o), e_s);
    chk(tg, "parity", int'(parity_o), e_p);
    chk(tg, "wb", int'(wb_o), e_wb);
    chk("R8", "valid", int'(valid_o), e_v);
    chk("R4", "sel", int'(reg_sel_o), e_sel);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pats[4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80; pats[3] = 8'h01;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", "result", int'(result_o), 0);
    chk("R9", "flags", int'({carry_o, zero_o, sign_o, parity_o}), 0);
    chk("R9", "wb/valid", int'({wb_o, valid_o}), 0);
    chk("R9", "sel", int'(reg_sel_o), 0);
    rst_ni = 1'b1;
    // R3 slot 6 on zero operand, carry in both values
    step(1, 8'h30, 8'h00, 0);
    step(1, 8'h37, 8'h00, 1);
    step(1, 8'h36, 8'hC3, 0);
    // R5 sign only for bit 7 test
    step(1, 8'h7E, 8'h80, 1);
    step(1, 8'h46, 8'h80, 0);
    // R6 flags held over set/clear, R8 idle hold
    step(1, 8'h00, 8'h80, 0);
    step(1, 8'hC5, 8'h00, 1);
    step(1, 8'h85, 8'hFF, 1);
    step(0, 8'h00, 8'h55, 1);
    step(0, 8'h3F, 8'hAA, 0);
    // full sweep of opcodes on edge operands
    for (int op = 0; op < 256; op++)
      for (int k = 0; k < 4; k++)
        step(1, op, pats[k], (op + k) % 2);
    // random with idle gaps
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule